// File: doc/BRIEF.md
# Selectable-Length Frame-Synchronous Scrambler

This block applies a frame-synchronous additive scrambler to a byte-parallel STM-1 or STM-0 stream. Each valid byte may carry a start-of-frame mark. The block restarts a pseudo-random sequence at a fixed point in every frame and XORs the sequence into the payload. It leaves the first-row section overhead unscrambled. In the transmit direction it also overwrites the framing positions with the two alignment byte values. In the receive direction, the same logic with insertion turned off removes the scrambling from a frame that has already been aligned.

A two-bit configuration input selects one of three generator lengths. The 7-stage polynomial serves ordinary line use. The 11-stage and 13-stage polynomials serve radio links, and the 13-stage one is the usual choice for STM-1 radio. The polynomial and the frame format are captured only on a start-of-frame byte, so a change made in the middle of a frame never corrupts the frame in progress.

Top module: `frame_scrambler`

## Requirements
- R1: While reset is asserted, and until the first valid input after its release, out_valid and out_sof are 0 and out_data is 0x00.
- R2: Every valid input byte appears on the outputs exactly one clock later, with out_valid set. A cycle without in_valid gives out_valid low one clock later. out_sof is high exactly when the byte was accepted with in_sof.
- R3: Until the first valid byte carrying in_sof after reset, each byte passes through unchanged.
- R4: In the sequence k0, k1, …, k0 through k(L-1) are 1. Each later bit is the XOR of the bits lying 6 and 7 places back (poly code 00, L=7). Byte number b of the scrambled region is XORed with k(8b) on bit 7 down to k(8b+7) on bit 0, so the first two keystream bytes are 0xFE and 0x04.
- R5: Poly code 01 uses L=11, with each later bit the XOR of the bits 9 and 11 places back.
- R6: Poly code 10 uses L=13, with each later bit the XOR of the bits 8, 9, 12 and 13 places back. Code 11 behaves as code 00.
- R7: Counting from 0 at the start-of-frame byte, byte positions below 9 (cfg_stm1=1) or below 3 (cfg_stm1=0) are not scrambled. The sequence restarts at the byte at position 9 or 3 respectively and runs through every later valid byte of the frame.
- R8: With cfg_insert=1, positions 0 to n-1 are output as 0xF6 and positions n to 2n-1 as 0x28, whatever the input. Here n=3 for STM-1 and n=1 for STM-0.
- R9: With cfg_insert=0, the framing positions and the other unscrambled overhead bytes pass through unchanged.
- R10: cfg_poly and cfg_stm1 are sampled only on a valid start-of-frame byte. Changes at any other time leave the frame in progress unaffected.
- R11: Cycles without in_valid do not advance the sequence or the byte position, and out_data holds its last value.
- R12: A new start-of-frame, including one that arrives early, restarts the position count, so every frame uses the same keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_poly | input | 2 | Polynomial select: 00/11 = 7-stage, 01 = 11-stage, 10 = 13-stage |
| cfg_stm1 | input | 1 | Frame format: 1 = STM-1, 0 = STM-0 |
| cfg_insert | input | 1 | 1 = overwrite framing bytes (transmit), 0 = pass them through (receive) |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Marks the first byte of a frame (qualified by in_valid) |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output first byte of frame |
| out_data | output | 8 | Scrambled or descrambled byte |

## Verification
The assertions take in_sof as meaningful only when in_valid is high. They also take cfg_insert as held steady across each accepted start-of-frame byte, because the framing-byte properties compare the output with the input of the previous cycle under that setting. The stimulus drives all inputs only at falling edges and changes cfg_insert only between frames. It changes cfg_poly and cfg_stm1 mid-frame only to show that those changes are ignored. Gaps, early frame starts and unsynchronised bytes are all sent through the same in_valid/in_sof handshake, so they stay within these assumptions.

// File: rtl/frame_scrambler.sv
module frame_scrambler #(
  parameter logic [7:0] A1_BYTE = 8'hF6,
  parameter logic [7:0] A2_BYTE = 8'h28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_poly,
  input  logic       cfg_stm1,
  input  logic       cfg_insert,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic [7:0] out_data
);
  localparam int WIN = 13;
  localparam int EXT = WIN + 8;

  logic           synced_q;
  logic [1:0]     poly_q;
  logic           stm1_q;
  logic [3:0]     pos_q;
  logic [WIN-1:0] win_q;

  wire       take_sof = in_valid & in_sof;
  wire [1:0] poly_e   = take_sof ? cfg_poly : poly_q;
  wire       stm1_e   = take_sof ? cfg_stm1 : stm1_q;
  wire [3:0] pos_e    = take_sof ? 4'd0 : pos_q;
  wire [3:0] soh_len  = stm1_e ? 4'd9 : 4'd3;
  wire [3:0] fa_cnt   = stm1_e ? 4'd3 : 4'd1;
  wire [3:0] fa_end   = {fa_cnt[2:0], 1'b0};
  wire       active   = synced_q | take_sof;
  wire       in_soh   = pos_e < soh_len;

  logic [WIN-1:0] seed;
  logic [EXT-1:0] seq;
  logic [7:0]     key;
  logic [7:0]     byte_o;

  always_comb
    case (poly_e)
      2'b01:   seed = 13'h07FF;
      2'b10:   seed = 13'h1FFF;
      default: seed = 13'h007F;
    endcase

  wire [WIN-1:0] win_e = (pos_e == soh_len) ? seed : win_q;

  always_comb begin
    seq = '0;
    seq[WIN-1:0] = win_e;
    for (int j = WIN; j < EXT; j++)
      case (poly_e)
        2'b01:   seq[j] = seq[j-9] ^ seq[j-11];
        2'b10:   seq[j] = seq[j-8] ^ seq[j-9] ^ seq[j-12] ^ seq[j-13];
        default: seq[j] = seq[j-6] ^ seq[j-7];
      endcase
    for (int i = 0; i < 8; i++) key[7-i] = seq[i];
  end

  always_comb begin
    byte_o = in_data;
    if (active && !in_soh)
      byte_o = in_data ^ key;
    else if (active && cfg_insert && pos_e < fa_cnt)
      byte_o = A1_BYTE;
    else if (active && cfg_insert && pos_e < fa_end)
      byte_o = A2_BYTE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
      synced_q  <= 1'b0;
      poly_q    <= '0;
      stm1_q    <= 1'b0;
      pos_q     <= '0;
      win_q     <= '1;
    end else begin
      out_valid <= in_valid;
      out_sof   <= take_sof;
      if (in_valid) begin
        out_data <= byte_o;
        pos_q    <= (pos_e > soh_len) ? pos_e : pos_e + 4'd1;
        if (take_sof) begin
          synced_q <= 1'b1;
          poly_q   <= cfg_poly;
          stm1_q   <= cfg_stm1;
        end
        if (active && !in_soh) win_q <= seq[EXT-1:8];
      end
    end
  end
endmodule

// File: rtl/frame_scrambler_chk.sv
module frame_scrambler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_insert,
  input logic       in_valid,
  input logic       in_sof,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_sof,
  input logic [7:0] out_data
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_sof_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> out_sof);
  a_r8_first_a1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && cfg_insert) |=> (out_data == 8'hF6));
  a_r9_sof_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !cfg_insert) |=> (out_data == $past(in_data)));
  a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
endmodule

bind frame_scrambler frame_scrambler_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_insert(cfg_insert),
  .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
  .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
);

// File: tb/test_frame_scrambler.sv
`timescale 1ns/1ps
module test_frame_scrambler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_poly = 2'b00;
  logic       cfg_stm1 = 1'b1;
  logic       cfg_insert = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_sof;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  frame_scrambler i_frame_scrambler (
    .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly), .cfg_stm1(cfg_stm1),
    .cfg_insert(cfg_insert), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
    .out_data(out_data)
  );

  always #2 clk = ~clk;

  // behavioural reference state
  bit         m_sync = 0;
  int         m_pos = 0;
  int         m_poly = 0;
  bit         m_stm1 = 0;
  bit         ks[$];
  int         kidx = 0;
  logic       e_valid = 0, e_sof = 0;
  logic [7:0] e_data = 0;

  function automatic int seq_len(int p);
    return (p == 1) ? 11 : (p == 2) ? 13 : 7;
  endfunction

  function automatic bit next_bit();
    while (ks.size() <= kidx) begin
      int n = ks.size();
      bit b;
      if (m_poly == 1)      b = ks[n-9] ^ ks[n-11];
      else if (m_poly == 2) b = ks[n-8] ^ ks[n-9] ^ ks[n-12] ^ ks[n-13];
      else                  b = ks[n-6] ^ ks[n-7];
      ks.push_back(b);
    end
    kidx++;
    return ks[kidx-1];
  endfunction

  task automatic model(input bit v, input bit s, input logic [7:0] d);
    if (!v) begin
      e_valid = 0; e_sof = 0;
      return;
    end
    e_valid = 1; e_sof = s;
    if (s) begin
      m_sync = 1; m_pos = 0; m_poly = cfg_poly; m_stm1 = cfg_stm1;
    end
    if (!m_sync) begin
      e_data = d;
      return;
    end
    begin
      int soh = m_stm1 ? 9 : 3;
      int na = m_stm1 ? 3 : 1;
      if (m_pos < soh) begin
        if (cfg_insert && m_pos < na) e_data = 8'hF6;
        else if (cfg_insert && m_pos < 2*na) e_data = 8'h28;
        else e_data = d;
      end else begin
        logic [7:0] k;
        if (m_pos == soh) begin
          ks.delete();
          for (int i = 0; i < seq_len(m_poly); i++) ks.push_back(1'b1);
          kidx = 0;
        end
        for (int i = 7; i >= 0; i--) k[i] = next_bit();
        e_data = d ^ k;
      end
      m_pos++;
    end
  endtask

  task automatic step(input bit v, input bit s, input logic [7:0] d, input string req);
    in_valid = v; in_sof = s; in_data = d;
    model(v, s, d);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== e_valid || out_sof !== e_sof || out_data !== e_data) begin
      errors++;
      $display("FAIL %s: got v=%0b s=%0b d=%02h, expected v=%0b s=%0b d=%02h",
               req, out_valid, out_sof, out_data, e_valid, e_sof, e_data);
    end
    in_valid = 0; in_sof = 0;
  endtask

  task automatic expect8(input logic [7:0] exp, input string req);
    checks++;
    if (out_data !== exp) begin
      errors++;
      $display("FAIL %s: got %02h, expected %02h", req, out_data, exp);
    end
  endtask

  task automatic frame(input int nbytes, input int seed, input bit gaps, input string req);
    for (int i = 0; i < nbytes; i++) begin
      step(1'b1, i == 0, 8'((i * 37 + seed) & 8'hFF), req);
      if (gaps && (i % 5 == 2)) step(1'b0, 1'b0, 8'hA5, "R11");
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] first_out [0:39];
    bit same;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_sof !== 0 || out_data !== 8'h00) begin
      errors++;
      $display("FAIL R1: got v=%0b s=%0b d=%02h, expected 0 0 00", out_valid, out_sof, out_data);
    end
    rst_n = 1;
    step(1'b0, 1'b0, 8'h00, "R1");

    // R3: no frame start seen yet
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'(8'h30 + i), "R3");

    // R4/R7/R8: STM-1, 7-stage, zero payload reveals keystream
    cfg_poly = 2'b00; cfg_stm1 = 1; cfg_insert = 1;
    for (int i = 0; i < 9; i++) step(1'b1, i == 0, 8'h55, "R8");
    step(1'b1, 1'b0, 8'h00, "R4");
    expect8(8'hFE, "R4");
    step(1'b1, 1'b0, 8'h00, "R4");
    expect8(8'h04, "R4");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 8'(i * 11), "R7");

    // R10: mid-frame config changes ignored
    cfg_poly = 2'b10; cfg_stm1 = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 8'(i + 3), "R10");

    // R5: STM-0, 11-stage, with gaps (R11)
    cfg_poly = 2'b01; cfg_stm1 = 0;
    frame(40, 7, 1'b1, "R5");

    // R6/R9: 13-stage, STM-1, receive direction
    cfg_poly = 2'b10; cfg_stm1 = 1; cfg_insert = 0;
    frame(50, 19, 1'b0, "R9");
    frame(30, 91, 1'b1, "R6");

    // R6: code 11 acts as 7-stage
    cfg_poly = 2'b11; cfg_insert = 1;
    for (int i = 0; i < 9; i++) step(1'b1, i == 0, 8'h00, "R6");
    step(1'b1, 1'b0, 8'h00, "R6");
    expect8(8'hFE, "R6");

    // R12: early restart inside overhead, then identical frames
    cfg_poly = 2'b01; cfg_stm1 = 0;
    frame(2, 4, 1'b0, "R12");
    for (int r = 0; r < 2; r++) begin
      same = 1;
      for (int i = 0; i < 40; i++) begin
        step(1'b1, i == 0, 8'h00, "R12");
        if (r == 0) first_out[i] = out_data;
        else if (first_out[i] !== out_data) same = 0;
      end
    end
    checks++;
    if (!same) begin
      errors++;
      $display("FAIL R12: got differing keystream, expected identical frames");
    end

    // R2: idle cycles produce no valid output
    step(1'b0, 1'b0, 8'h00, "R2");
    step(1'b0, 1'b0, 8'h00, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule